// File: doc/BRIEF.md
# Streaming Block-Program Sequencer (host side)

This controller sits on the programming-equipment side of a parallel flash-style device. It writes a whole erased block in a single streaming session. It takes a block base word address, a post-confirm delay and a stream of data words with valid/ready handshaking. A last flag marks the final word. The device is driven over a simple bus that writes in one cycle and reads in two cycles.

A session opens with a two-write command pair sent to the base address. The sequencer then waits for the programmed delay and polls the ready bit. The data goes out in fixed-size groups. Before each group the sequencer polls until the device reports that its buffer is free. Every data write goes to the base address, because the device advances its own internal address. A short final group is filled with erased words. The session closes with a write to a different address and one more ready poll.

No read-back verify is performed. Any device error reported during a poll stops the session and records the phase in which it happened.

Top module: `bufprog_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `err`, `s_ready`, `bus_we` and `bus_re` are all low.
- R2: A `start` whose `base_addr` has any of its low log2(GROUP_WORDS) bits set is refused. No bus operation follows, and `err` rises with `err_code` = 1.
- R3: An accepted `start` writes CMD_SETUP (0x0080) and then CMD_CONFIRM (0x00D0) to `base_addr`, in two consecutive cycles.
- R4: The first status read is issued `delay_cycles`+2 cycles after the confirm write. A read holds `bus_re` for one cycle, and `bus_rdata` is sampled in the following cycle. Reads repeat until status bit 7 is 1.
- R5: Before every group, status is read repeatedly until bit 0 is 0 (bit 0 = 1 means the device buffer is busy).
- R6: Each accepted stream beat produces one write of `s_data` to `base_addr`, in stream order. `s_ready` is high only while a group is being filled. All status reads use `base_addr`. `bus_we` and `bus_re` are never high together.
- R7: Once the word carrying `s_last` has been written, the rest of its group is written as 0xFFFF and `s_ready` stays low.
- R8: If word number BLOCK_WORDS is accepted without `s_last`, the session aborts after that write. No further bus operation follows, and `err_code` = 5.
- R9: After the final group, the sequencer polls bit 0 as in R5. It then writes 0xFFFF to `base_addr`+1 and polls bit 7 until it is 1. It then raises `done`, which stays high until the next `start`.
- R10: Any read in which a status bit under mask 0x3A (bits 5, 4, 3, 1) is set aborts the session. The code is 2 during the ready poll after confirm, 3 during a group poll and 4 during the exit poll. Errors take precedence over the ready bits, and `err`/`err_code` hold until the next `start`.
- R11: No read or write is issued after `done` rises (no verify pass).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a session (accepted while not busy) |
| base_addr | input | AW | Block first-word address |
| delay_cycles | input | DLY_W | Wait after confirm before the first status read |
| s_valid | input | 1 | Stream word valid |
| s_ready | output | 1 | Stream word accepted this cycle when valid |
| s_data | input | DW | Stream word |
| s_last | input | 1 | Marks the final stream word |
| bus_we | output | 1 | Device write strobe |
| bus_re | output | 1 | Device status read strobe |
| bus_addr | output | AW | Device word address |
| bus_wdata | output | DW | Device write data |
| bus_rdata | input | 8 | Device status, valid the cycle after `bus_re` |
| busy | output | 1 | Session in progress |
| done | output | 1 | Session completed cleanly |
| err | output | 1 | Session aborted |
| err_code | output | 3 | 1 misaligned, 2 setup, 3 group, 4 exit, 5 overflow |

## Verification
The bench builds the block with GROUP_WORDS = 8, BLOCK_WORDS = 32, AW = 16 and DLY_W = 8. With these sizes a completely full block, a block overrun and padded or unpadded final groups each take only a few dozen cycles, so all of them fit in one short run. It also brings the alignment check within reach with ordinary small addresses. A scripted status responder sets the number of busy polls and injects an error in each phase. The bench predicts every bus operation in order, including the delay gap after confirm.

// File: rtl/bufprog_seq.sv
module bufprog_seq #(
  parameter int AW = 24,
  parameter int DW = 16,
  parameter int GROUP_WORDS = 512,
  parameter int BLOCK_WORDS = 65536,
  parameter int DLY_W = 16,
  parameter logic [DW-1:0] CMD_SETUP = 16'h0080,
  parameter logic [DW-1:0] CMD_CONFIRM = 16'h00D0,
  parameter logic [7:0] ERR_MASK = 8'h3A
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    base_addr,
  input  logic [DLY_W-1:0] delay_cycles,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [DW-1:0]    s_data,
  input  logic             s_last,
  output logic             bus_we,
  output logic             bus_re,
  output logic [AW-1:0]    bus_addr,
  output logic [DW-1:0]    bus_wdata,
  input  logic [7:0]       bus_rdata,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [2:0]       err_code
);
  localparam int GW = $clog2(GROUP_WORDS);
  localparam int TW = $clog2(BLOCK_WORDS + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_SETUP, S_CONF, S_WAIT, S_P7R, S_P7C, S_P0R, S_P0C,
    S_DATA, S_EXIT, S_X7R, S_X7C, S_DONE, S_FAIL
  } st_t;

  st_t st;
  logic [AW-1:0]    wa0;
  logic [DLY_W-1:0] dly;
  logic [GW-1:0]    wcnt;
  logic [TW-1:0]    tot;
  logic             pad, fin;
  logic [2:0]       code;

  wire aligned = base_addr[GW-1:0] == '0;
  wire rd_err  = |(bus_rdata & ERR_MASK);
  wire take    = (st == S_DATA) && (pad || s_valid);
  wire grp_end = take && (wcnt == GW'(GROUP_WORDS - 1));
  wire acc     = s_valid && s_ready;
  wire rest    = (st == S_IDLE) || (st == S_DONE) || (st == S_FAIL);

  assign s_ready   = (st == S_DATA) && !pad;
  assign bus_we    = (st == S_SETUP) || (st == S_CONF) || (st == S_EXIT) || take;
  assign bus_re    = (st == S_P7R) || (st == S_P0R) || (st == S_X7R);
  assign bus_addr  = (st == S_EXIT) ? wa0 + AW'(1) : wa0;
  assign bus_wdata = (st == S_SETUP) ? CMD_SETUP :
                     (st == S_CONF)  ? CMD_CONFIRM :
                     (st == S_DATA && !pad) ? s_data : '1;
  assign busy      = !rest;
  assign done      = st == S_DONE;
  assign err       = st == S_FAIL;
  assign err_code  = code;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; wa0 <= '0; dly <= '0; wcnt <= '0; tot <= '0;
      pad <= 1'b0; fin <= 1'b0; code <= '0;
    end else begin
      case (st)
        S_IDLE, S_DONE, S_FAIL:
          if (start) begin
            if (!aligned) begin
              st <= S_FAIL; code <= 3'd1;
            end else begin
              st <= S_SETUP; wa0 <= base_addr; dly <= delay_cycles; code <= '0;
              wcnt <= '0; tot <= '0; pad <= 1'b0; fin <= 1'b0;
            end
          end
        S_SETUP: st <= S_CONF;
        S_CONF:  st <= S_WAIT;
        S_WAIT:  if (dly == '0) st <= S_P7R; else dly <= dly - 1'b1;
        S_P7R:   st <= S_P7C;
        S_P7C:
          if (rd_err) begin st <= S_FAIL; code <= 3'd2; end
          else if (bus_rdata[7]) st <= S_P0R;
          else st <= S_P7R;
        S_P0R:   st <= S_P0C;
        S_P0C:
          if (rd_err) begin st <= S_FAIL; code <= 3'd3; end
          else if (!bus_rdata[0]) st <= fin ? S_EXIT : S_DATA;
          else st <= S_P0R;
        S_DATA: begin
          if (take) wcnt <= grp_end ? '0 : wcnt + 1'b1;
          if (acc) begin
            tot <= tot + 1'b1;
            if (s_last) pad <= 1'b1;
          end
          if (acc && !s_last && tot == TW'(BLOCK_WORDS - 1)) begin
            st <= S_FAIL; code <= 3'd5;
          end else if (grp_end) begin
            fin <= pad || (acc && s_last);
            st <= S_P0R;
          end
        end
        S_EXIT:  st <= S_X7R;
        S_X7R:   st <= S_X7C;
        S_X7C:
          if (rd_err) begin st <= S_FAIL; code <= 3'd4; end
          else if (bus_rdata[7]) st <= S_DONE;
          else st <= S_X7R;
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r6_one_op: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_re));
  a_r6_stream_to_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |-> (bus_we && bus_wdata == s_data && bus_addr == wa0));
  a_r2_misaligned: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && base_addr[GW-1:0] != '0) |=> (err && err_code == 3'd1));
  a_r9_done_on_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(bus_rdata[7]) && ($past(bus_rdata & ERR_MASK) == 8'h00)));
  a_r10_err_held: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !start) |=> (err && $stable(err_code)));
  a_r11_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(bus_we || bus_re));
endmodule

// File: tb/test_bufprog_seq.sv
module test_bufprog_seq;
  localparam int AW = 16, DW = 16, G = 8, B = 32;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0, s_valid = 1'b0, s_last = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic [7:0] delay_cycles = '0;
  logic [DW-1:0] s_data = '0;
  logic [7:0] bus_rdata = 8'h00;
  logic s_ready, bus_we, bus_re, busy, done, err;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [2:0] err_code;

  bufprog_seq #(.AW(AW), .DW(DW), .GROUP_WORDS(G), .BLOCK_WORDS(B), .DLY_W(8)) i_bufprog_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr), .delay_cycles(delay_cycles),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
    .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .busy(busy), .done(done), .err(err), .err_code(err_code));

  typedef struct { logic we; logic [AW-1:0] a; logic [DW-1:0] d; string req; } op_t;
  op_t expq[$];
  logic [7:0] stq[$];
  op_t e;
  int n_run = 0, n_fail = 0, cyc = 0, t_conf = -1, t_rd = -1;
  logic stop = 1'b0;

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk)
    if (bus_re) bus_rdata <= (stq.size() > 0) ? stq.pop_front() : 8'h80;

  always @(negedge clk) if (rst_n) begin
    cyc++;
    if (bus_we && bus_re) chk(0, "R6", "read and write together", 1, 0);
    if (bus_re && s_ready) chk(0, "R6", "s_ready during read", 1, 0);
    if (bus_we || bus_re) begin
      if (expq.size() == 0) chk(0, "R11", "unexpected bus op", {bus_we, bus_addr, bus_wdata}, 0);
      else begin
        e = expq.pop_front();
        chk(e.we == bus_we && e.a == bus_addr && (!e.we || e.d == bus_wdata), e.req, "bus op",
            {bus_we, bus_addr, bus_wdata}, {e.we, e.a, e.we ? e.d : bus_wdata});
      end
      if (bus_we && bus_wdata == 16'h00D0) t_conf = cyc;
      if (bus_re && t_conf >= 0 && t_rd < 0) t_rd = cyc;
    end
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  function automatic logic [DW-1:0] wv(int i, int seed);
    return 16'(16'h2000 + i * 7 + seed * 256);
  endfunction

  task automatic exp_w(logic [AW-1:0] a, logic [DW-1:0] d, string req);
    op_t o; o.we = 1'b1; o.a = a; o.d = d; o.req = req; expq.push_back(o);
  endtask
  task automatic exp_r(logic [AW-1:0] a, string req);
    op_t o; o.we = 1'b0; o.a = a; o.d = '0; o.req = req; expq.push_back(o);
  endtask
  task automatic poll(logic [AW-1:0] a, int nbusy, logic [7:0] busyv, logic [7:0] okv, string req);
    for (int k = 0; k < nbusy; k++) begin stq.push_back(busyv); exp_r(a, req); end
    stq.push_back(okv); exp_r(a, req);
  endtask
  task automatic plan_open(logic [AW-1:0] a, int nb7);
    exp_w(a, 16'h0080, "R3"); exp_w(a, 16'h00D0, "R3");
    poll(a, nb7, 8'h00, 8'h80, "R4");
  endtask
  task automatic plan_groups(logic [AW-1:0] a, int n, int seed, int ngroups);
    for (int g = 0; g < ngroups; g++) begin
      poll(a, g % 2, 8'h81, 8'h80, "R5");
      for (int j = 0; j < G; j++) begin
        if (g * G + j < n) exp_w(a, wv(g * G + j, seed), "R6");
        else exp_w(a, 16'hFFFF, "R7");
      end
    end
  endtask
  task automatic plan_close(logic [AW-1:0] a, logic [7:0] x7);
    poll(a, 1, 8'h81, 8'h80, "R9");
    exp_w(a + 16'd1, 16'hFFFF, "R9");
    poll(a, 1, 8'h00, x7, "R9");
  endtask

  task automatic stream(int n, bit mark_last, int seed);
    for (int i = 0; i < n && !stop; i++) begin
      repeat ((i * seed) % 3) @(negedge clk);
      s_valid = 1'b1; s_data = wv(i, seed); s_last = mark_last && (i == n - 1);
      while (!s_ready && !stop) @(negedge clk);
      @(negedge clk);
      s_valid = 1'b0; s_last = 1'b0;
    end
  endtask

  task automatic run(logic [AW-1:0] a, int dly, int n, bit mark_last, int seed,
                     bit exp_done, int exp_code, string req);
    t_conf = -1; t_rd = -1; stop = 1'b0;
    @(negedge clk); base_addr = a; delay_cycles = 8'(dly); start = 1'b1;
    @(negedge clk); start = 1'b0;
    fork
      stream(n, mark_last, seed);
      begin
        int k = 0;
        while (!done && !err && k < 3000) begin @(negedge clk); k++; end
        repeat (6) @(negedge clk);
        stop = 1'b1;
      end
    join
    s_valid = 1'b0;
    chk(expq.size() == 0, req, "pending expected ops", expq.size(), 0);
    chk(done == exp_done, req, "done", done, exp_done);
    chk(err == !exp_done, req, "err", err, !exp_done);
    chk(err_code == 3'(exp_code), req, "err_code", err_code, exp_code);
    chk(!busy && !bus_we && !bus_re, "R11", "quiet at end", {busy, bus_we, bus_re}, 0);
    expq.delete(); stq.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !s_ready && !bus_we && !bus_re, "R1", "reset state",
        {busy, done, err, s_ready, bus_we, bus_re}, 0);
    rst_n = 1'b1;

    run(16'h0104, 2, 0, 1, 1, 0, 1, "R2");

    plan_open(16'h0040, 2); plan_groups(16'h0040, 13, 1, 2); plan_close(16'h0040, 8'h80);
    run(16'h0040, 3, 13, 1, 1, 1, 0, "R7");
    chk(t_rd - t_conf == 5, "R4", "confirm-to-read gap", t_rd - t_conf, 5);

    plan_open(16'h0080, 0); plan_groups(16'h0080, 32, 2, 4); plan_close(16'h0080, 8'h80);
    run(16'h0080, 0, 32, 1, 2, 1, 0, "R9");
    chk(t_rd - t_conf == 2, "R4", "confirm-to-read gap", t_rd - t_conf, 2);

    plan_open(16'h00C0, 1); plan_groups(16'h00C0, 32, 1, 4);
    run(16'h00C0, 1, 32, 0, 1, 0, 5, "R8");

    exp_w(16'h0040, 16'h0080, "R3"); exp_w(16'h0040, 16'h00D0, "R3");
    poll(16'h0040, 1, 8'h00, 8'h92, "R10");
    run(16'h0040, 1, 5, 1, 1, 0, 2, "R10");

    plan_open(16'h0048, 0); poll(16'h0048, 1, 8'h81, 8'h88, "R10");
    run(16'h0048, 0, 5, 1, 2, 0, 3, "R10");

    plan_open(16'h0050, 0); plan_groups(16'h0050, 3, 2, 1); plan_close(16'h0050, 8'hA0);
    run(16'h0050, 2, 3, 1, 2, 0, 4, "R10");

    plan_open(16'h0100, 1); plan_groups(16'h0100, 8, 3, 1); plan_close(16'h0100, 8'h80);
    run(16'h0100, 4, 8, 1, 3, 1, 0, "R9");
    chk(t_rd - t_conf == 6, "R4", "confirm-to-read gap", t_rd - t_conf, 6);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule